// File: doc/BRIEF.md
# Sleep-Aligned Timer Start/Stop Controller

This block is a fast-clock timer made of a 16-bit period counter and a 20-bit wrap counter. The period counter counts from zero up to the programmed period minus one, returns to zero and bumps the wrap counter. Software drives two control bits: `run` and `sync`. With `sync` low, `run` starts and stops the timer on the next fast clock edge.

With `sync` high, both transitions wait for the next rising edge of a slow sleep tick. That tick already arrives synchronized to the fast clock. On a deferred stop, the block keeps counting until the edge and then records the free-running 24-bit sleep count. On a deferred start, the block waits for the edge and reads the sleep count again. A calculator then turns the sleep interval into fast-clock counts, using a ratio of 15625/16 with rounding. It adds the held timer value and a fixed overhead of 75, then splits the total into a new timer value and an increment for the wrap counter. Both values are loaded 75 fast cycles after the edge, so the timer looks as if it never stopped.

Top module: `slp_sync_timer`

## Requirements
- R1: After reset the period counter and the wrap counter are both 0, `running` is 0 and `start_done` is 0.
- R2: With `sync` low, raising `run` sets `running` one edge later, and the counter holds 0 for that edge. The period counter then increments at every edge taken while running. Clearing `run` stops the timer one edge later, and that final edge still increments.
- R3: While running, the period counter goes from P-1 to 0 and the wrap counter increments modulo 2^20 at that edge. P is the value on `period`.
- R4: A `period` value of 0 means P = 65536: the counter reaches 65535 before it wraps.
- R5: With `sync` high, clearing `run` while running does not stop the timer. Counting goes on until an edge at which the slow tick is 1 after having been 0 one edge before. That edge increments the counter and stops it, and the sleep count is stored. Afterwards both counters stay frozen.
- R6: With `sync` high, raising `run` while stopped keeps the timer stopped until a slow tick rising edge. If `run` is cleared before that edge, the timer never starts.
- R7: For a deferred start, D = (now − stored) mod 2^24, and D = 2^24 when that difference is 0. C = floor((D·15625 + 8)/16) + Tc + 75, where Tc is the held period count. The period counter is loaded with C mod P. The wrap counter is loaded with (C div P + held wrap count) mod 2^20. The load becomes visible 75 fast edges after the tick edge, counting the tick edge as the first.
- R8: `start_done` is high for exactly one cycle, the cycle in which the compensated values first appear.
- R9: A slow tick held high produces only one edge; a level held at 1 never stops or starts the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run request bit |
| sync | input | 1 | Align start/stop to slow tick edges |
| slow_tick | input | 1 | Slow sleep clock, already synchronized |
| sleep_cnt | input | 24 | Free-running sleep counter value |
| period | input | 16 | Timer period, 0 means 65536 |
| tmr_cnt | output | 16 | Period counter |
| ovf_cnt | output | 20 | Wrap counter |
| running | output | 1 | Timer is in the run state |
| start_done | output | 1 | One-cycle pulse when compensated values are loaded |

## Verification
The bench checks several vectors of compensated restarts. These cover a sleep count that wraps past 2^24, equal stored and current sleep counts (a full 2^24 interval), a period of 1 that forces the wrap counter past 2^20, and the 65536 period. An off-by-one in rounding, division or overhead shows up as a wrong loaded value. An error in the latency counter moves `start_done` and the load one cycle early or late.

Directed tests hold the tick high across a stop request. A design that treats a level as an edge would stop at once. Other tests cancel an armed start before the edge, where a faulty design would start anyway. A further test checks that the last increment on an immediate stop is kept; a design that drops it ends one count short.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOAD  = 2'd2,
        ST_RUN   = 2'd3
    } sst_state_e;
endpackage

// File: rtl/sst_tick_edge.sv
module sst_tick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic rise
);
    logic tick_d, tick_q;

    always_comb begin
        tick_d = tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= tick_d;
    end

    // a rise is a 1 now after a 0 at the previous edge
    assign rise = tick & ~tick_q;
endmodule

// File: rtl/sst_wrap_counter.sv
module sst_wrap_counter #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [OVF_W-1:0] load_ovf,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic [OVF_W-1:0] ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [OVF_W-1:0] ovf;
    } cnt_t;

    cnt_t             d, q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        // period 0 wraps to all ones, i.e. a full 2^CNT_W period
        last_val = period - CNT_W'(1);
        d = q;
        if (load) begin
            d.cnt = load_cnt;
            d.ovf = load_ovf;
        end else if (inc) begin
            if (q.cnt >= last_val) begin
                d.cnt = '0;
                d.ovf = q.ovf + OVF_W'(1);
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;
    assign ovf = q.ovf;
endmodule

// File: rtl/sst_comp_calc.sv
module sst_comp_calc #(
    parameter int CNT_W       = 16,
    parameter int OVF_W       = 20,
    parameter int SLP_W       = 24,
    parameter int OVERHEAD    = 75,
    parameter int RATIO_NUM   = 15625,
    parameter int RATIO_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SLP_W-1:0] now_slp,
    input  logic [SLP_W-1:0] held_slp,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] res_cnt,
    output logic [OVF_W-1:0] res_quo,
    output logic             done
);
    localparam int ND_W   = SLP_W + 1;
    localparam int NUM_W  = $clog2(RATIO_NUM + 1);
    localparam int PROD_W = ND_W + NUM_W;
    localparam int C_W    = PROD_W - RATIO_SHIFT + 2;
    localparam int REM_W  = CNT_W + 1;
    localparam int DIV_W  = CNT_W + 2;
    localparam int IT_W   = $clog2(C_W + 1);
    localparam int HALF   = (RATIO_SHIFT > 0) ? (1 << (RATIO_SHIFT - 1)) : 0;

    typedef struct packed {
        logic [C_W-1:0]   dvd;   // dividend, quotient shifts in from the bottom
        logic [REM_W-1:0] rem;
        logic [DIV_W-1:0] dsr;
        logic [IT_W-1:0]  it;
        logic             busy;
        logic             done;
    } div_t;

    div_t              d, q;
    logic [SLP_W-1:0]  gap;
    logic [ND_W-1:0]   nd;
    logic [PROD_W-1:0] prod;
    logic [C_W-1:0]    c_val;
    logic [DIV_W-1:0]  sh;
    logic              qbit;

    always_comb begin
        gap   = now_slp - held_slp;
        nd    = (gap == '0) ? {1'b1, {SLP_W{1'b0}}} : {1'b0, gap};
        prod  = PROD_W'(nd) * PROD_W'(RATIO_NUM);
        c_val = C_W'((prod + PROD_W'(HALF)) >> RATIO_SHIFT)
              + C_W'(cur_cnt) + C_W'(OVERHEAD);
        sh    = {q.rem, q.dvd[C_W-1]};
        qbit  = 1'b0;
        d     = q;
        if (start) begin
            d.dvd  = c_val;
            d.rem  = '0;
            d.dsr  = (period == '0) ? {1'b0, 1'b1, {CNT_W{1'b0}}} : DIV_W'(period);
            d.it   = IT_W'(C_W);
            d.busy = 1'b1;
            d.done = 1'b0;
        end else if (q.busy) begin
            if (sh >= q.dsr) begin
                d.rem = REM_W'(sh - q.dsr);
                qbit  = 1'b1;
            end else begin
                d.rem = REM_W'(sh);
            end
            d.dvd = {q.dvd[C_W-2:0], qbit};
            d.it  = q.it - IT_W'(1);
            if (q.it == IT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_cnt = q.rem[CNT_W-1:0];
    assign res_quo = q.dvd[OVF_W-1:0];
    assign done    = q.done;
endmodule

// File: rtl/slp_sync_timer.sv
module slp_sync_timer
    import sst_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int OVF_W       = 20,
    parameter int SLP_W       = 24,
    parameter int START_LAT   = 75,
    parameter int RATIO_NUM   = 15625,
    parameter int RATIO_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync,
    input  logic             slow_tick,
    input  logic [SLP_W-1:0] sleep_cnt,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] tmr_cnt,
    output logic [OVF_W-1:0] ovf_cnt,
    output logic             running,
    output logic             start_done
);
    localparam int LAT_W = $clog2(START_LAT + 1);

    typedef struct packed {
        sst_state_e       st;
        logic             stop_pend;
        logic [SLP_W-1:0] held;
        logic [LAT_W-1:0] lat;
        logic             done;
    } ctl_t;

    ctl_t             d, q;
    logic             rise;
    logic             calc_start, calc_done;
    logic             cnt_load, cnt_inc;
    logic [CNT_W-1:0] calc_cnt;
    logic [OVF_W-1:0] calc_quo;

    sst_tick_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (slow_tick),
        .rise  (rise)
    );

    sst_comp_calc #(
        .CNT_W       (CNT_W),
        .OVF_W       (OVF_W),
        .SLP_W       (SLP_W),
        .OVERHEAD    (START_LAT),
        .RATIO_NUM   (RATIO_NUM),
        .RATIO_SHIFT (RATIO_SHIFT)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (calc_start),
        .now_slp  (sleep_cnt),
        .held_slp (q.held),
        .cur_cnt  (tmr_cnt),
        .period   (period),
        .res_cnt  (calc_cnt),
        .res_quo  (calc_quo),
        .done     (calc_done)
    );

    sst_wrap_counter #(
        .CNT_W (CNT_W),
        .OVF_W (OVF_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_inc),
        .load     (cnt_load),
        .load_cnt (calc_cnt),
        .load_ovf (calc_quo + ovf_cnt),
        .period   (period),
        .cnt      (tmr_cnt),
        .ovf      (ovf_cnt)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        calc_start = 1'b0;
        cnt_load   = 1'b0;
        cnt_inc    = (q.st == ST_RUN);
        case (q.st)
            ST_IDLE: begin
                if (run) d.st = sync ? ST_ARMED : ST_RUN;
            end
            ST_ARMED: begin
                if (!run) begin
                    d.st = ST_IDLE;
                end else if (rise) begin
                    d.st       = ST_LOAD;
                    d.lat      = LAT_W'(1);
                    calc_start = 1'b1;
                end
            end
            ST_LOAD: begin
                d.lat = q.lat + LAT_W'(1);
                if (q.lat >= LAT_W'(START_LAT - 1) && calc_done) begin
                    cnt_load    = 1'b1;
                    d.st        = ST_RUN;
                    d.done      = 1'b1;
                    d.stop_pend = 1'b0;
                end
            end
            ST_RUN: begin
                if (run) begin
                    d.stop_pend = 1'b0;
                end else if (!sync) begin
                    d.st        = ST_IDLE;
                    d.stop_pend = 1'b0;
                end else if (rise) begin
                    d.st        = ST_IDLE;
                    d.held      = sleep_cnt;
                    d.stop_pend = 1'b0;
                end else begin
                    d.stop_pend = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign running    = (q.st == ST_RUN);
    assign start_done = q.done;
endmodule

// File: rtl/sst_checker.sv
module sst_checker #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [OVF_W-1:0] ovf_cnt,
    input logic             running,
    input logic             start_done
);
    // R2: every edge taken while running advances the count by one or wraps it
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (tmr_cnt == $past(tmr_cnt) + CNT_W'(1)) || (tmr_cnt == '0));

    // R3: the count stays below a stable nonzero period
    a_r3_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        running && (period != '0) && $stable(period) |-> tmr_cnt < period);

    // R5: counters are frozen while stopped, except for a compensated load
    a_r5_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> ($stable(tmr_cnt) && $stable(ovf_cnt)) || start_done);

    // R6: in aligned mode the timer only enters run through a load
    a_r6_start_via_load: assert property (@(posedge clk) disable iff (!rst_n)
        !running && sync |=> !running || start_done);

    // R8: the done pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_done);

    // R8: the done pulse comes with the run state
    a_r8_done_running: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> running);
endmodule

bind slp_sync_timer sst_checker #(
    .CNT_W (CNT_W),
    .OVF_W (OVF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .period     (period),
    .tmr_cnt    (tmr_cnt),
    .ovf_cnt    (ovf_cnt),
    .running    (running),
    .start_done (start_done)
);

// File: tb/sim_slp_sync_timer.sv
module sim_slp_sync_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        sync = 1'b0;
    logic        slow_tick = 1'b0;
    logic [23:0] sleep_cnt = '0;
    logic [15:0] period = '0;
    logic [15:0] tmr_cnt;
    logic [19:0] ovf_cnt;
    logic        running;
    logic        start_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    slp_sync_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sync       (sync),
        .slow_tick  (slow_tick),
        .sleep_cnt  (sleep_cnt),
        .period     (period),
        .tmr_cnt    (tmr_cnt),
        .ovf_cnt    (ovf_cnt),
        .running    (running),
        .start_done (start_done)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [23:0] ns;
        logic [23:0] nc;
        logic [15:0] cyc;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{16'd1000,  24'd100,       24'd200,       16'd50},
        '{16'd0,     24'hFFFFF0,    24'h000010,    16'd10},
        '{16'd1,     24'd5,         24'd5,         16'd3},
        '{16'd7,     24'd0,         24'hFFFFFF,    16'd20},
        '{16'd40000, 24'd1234,      24'd99999,     16'd100}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; sync = 1'b0; slow_tick = 1'b0; sleep_cnt = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    function automatic longint unsigned comp_c(input logic [23:0] ns, input logic [23:0] nc,
                                               input longint unsigned tc);
        longint unsigned nd;
        nd = longint'((nc - ns) & 24'hFFFFFF);
        if (nd == 0) nd = 64'd1 << 24;
        return (nd * 15625 + 8) / 16 + tc + 75;
    endfunction

    initial begin
        step(1);
        // R1: reset state
        rst_n = 1'b0;
        step(2);
        chk("R1 tmr", tmr_cnt, 0);
        chk("R1 ovf", ovf_cnt, 0);
        chk("R1 running", running, 0);
        chk("R1 done", start_done, 0);

        // vector walk: aligned stop, aligned start, compensated load
        for (int i = 0; i < NVEC; i++) begin
            longint unsigned pp, cc, tc, oc;
            do_reset();
            period = VECS[i].per;
            pp = (VECS[i].per == 0) ? 65536 : longint'(VECS[i].per);
            run = 1'b1;
            step(int'(VECS[i].cyc) + 1);
            chk("R2 running", running, 1);
            chk("R3 count", tmr_cnt, longint'(VECS[i].cyc) % pp);
            sync = 1'b1; run = 1'b0;
            step(4);
            chk("R5 pending stop still running", running, 1);
            sleep_cnt = VECS[i].ns; slow_tick = 1'b1;
            step(1);
            chk("R5 stopped at tick", running, 0);
            tc = tmr_cnt; oc = ovf_cnt;
            step(3);
            chk("R5 frozen", tmr_cnt, longint'(tc));
            slow_tick = 1'b0;
            step(2);
            sleep_cnt = VECS[i].nc; run = 1'b1;
            step(5);
            chk("R6 waits for tick", running, 0);
            chk("R6 count held", tmr_cnt, longint'(tc));
            slow_tick = 1'b1;
            step(1);
            chk("R6 not yet running", running, 0);
            step(73);
            chk("R7 no early load", tmr_cnt, longint'(tc));
            chk("R8 no early done", start_done, 0);
            step(1);
            cc = comp_c(VECS[i].ns, VECS[i].nc, tc);
            chk("R8 done pulse", start_done, 1);
            chk("R7 running", running, 1);
            chk("R7 timer value", tmr_cnt, cc % pp);
            chk("R7 wrap value", ovf_cnt, ((cc / pp) + oc) % (64'd1 << 20));
            step(1);
            chk("R8 pulse ends", start_done, 0);
            // R9: tick held high is not an edge
            run = 1'b0;
            step(4);
            chk("R9 level is not edge", running, 1);
            slow_tick = 1'b0;
            step(1);
            slow_tick = 1'b1;
            step(1);
            chk("R5 stop on fresh edge", running, 0);
            slow_tick = 1'b0; sync = 1'b0;
            step(2);
        end

        // R2: immediate start and stop, last edge still counts
        do_reset();
        run = 1'b1;
        step(1);
        chk("R2 immediate start", running, 1);
        chk("R2 first edge holds 0", tmr_cnt, 0);
        step(10);
        chk("R2 count", tmr_cnt, 10);
        run = 1'b0;
        step(1);
        chk("R2 immediate stop", running, 0);
        chk("R2 last edge counted", tmr_cnt, 11);
        step(5);
        chk("R2 frozen", tmr_cnt, 11);

        // R3: short period wrap
        do_reset();
        period = 16'd3; run = 1'b1;
        step(3);
        chk("R3 at P-1", tmr_cnt, 2);
        chk("R3 no wrap yet", ovf_cnt, 0);
        step(1);
        chk("R3 wrapped", tmr_cnt, 0);
        chk("R3 wrap count", ovf_cnt, 1);

        // R4: period 0 counts to 65535
        do_reset();
        period = 16'd0; run = 1'b1;
        step(65536);
        chk("R4 top", tmr_cnt, 65535);
        chk("R4 no wrap", ovf_cnt, 0);
        step(1);
        chk("R4 wrapped", tmr_cnt, 0);
        chk("R4 wrap count", ovf_cnt, 1);

        // R6: cancel an armed start
        do_reset();
        sync = 1'b1; run = 1'b1;
        step(3);
        run = 1'b0;
        step(1);
        slow_tick = 1'b1;
        step(80);
        chk("R6 cancelled start", running, 0);
        chk("R6 cancelled count", tmr_cnt, 0);
        chk("R6 no done", start_done, 0);
        slow_tick = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule